// File: doc/BRIEF.md
# Tick-Counting Real-Time Clock with Alarm Compare

This block keeps time as a 48-bit count of ticks from a 32768 Hz timebase enable, so the low 15 bits hold the fraction of a second and bits 47:15 hold whole seconds. Software reaches the count through a 16-bit register bus as three words. A write to any one of those words sets that slice of the count directly. Converting the count to a calendar date and choosing an epoch are left to software.

A second group of three words holds a 48-bit alarm value. When a timebase tick moves the count onto the alarm value, a sticky status flag sets. An enable bit gates that flag onto the interrupt line. Software clears the flag by writing a 1 to it. The three count words cannot be read atomically. Software therefore reads them twice and compares the two results, and the block keeps every register and the read-data output steady between bus accesses unless a tick arrives.

Top module: `rtc_elapsed_alarm`

## Requirements
- R1: After reset the count, the alarm value, the status flag, the enable bit and the read data are all zero, and `alarm_irq` is low.
- R2: The count rises by exactly one in each cycle where `tick_en` is high and no count word is written, and it wraps from all ones to zero. In every other cycle without a count-word write, it holds its value.
- R3: A read with `bus_rd` high returns its word on `bus_rdata` one cycle later. Address 0x00 returns count bits 15:0, 0x02 returns bits 31:16 and 0x04 returns bits 47:32. The value stays on `bus_rdata` until the next read.
- R4: A write to a count word replaces only that 16-bit slice, starting on the next clock. A tick in the same cycle is dropped: the other slices keep their values and nothing is added.
- R5: The alarm words at 0x08, 0x0a and 0x0c (bits 15:0, 31:16 and 47:32) can be written and read back, and writing them does not change the count.
- R6: The status flag, read as bit 0 at 0x3e, sets on the same edge where a tick moves the count to equal the alarm value. It does not set when the count reaches that value through a count-word write, and it does not set while the count sits idle at the alarm value.
- R7: Writing 0x3e with bit 0 set clears the status flag, and writing it with bit 0 clear leaves the flag as it is. If a match occurs in the same cycle as a clear, the flag stays set.
- R8: `alarm_irq` equals the status flag ANDed with the enable bit, which is bit 0 at 0x3c and reads back there.
- R9: The reserved offsets 0x06 and 0x0e read as zero, as does every other unmapped address, including odd ones. Writes to these addresses change neither the count, the alarm value, the flag nor the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable from the 32768 Hz timebase |
| bus_addr | input | 6 | Byte address; bit 5 selects the second bank |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 16 | Read data, registered, held between reads |
| alarm_irq | output | 1 | Alarm interrupt, status flag gated by the enable bit |

## Verification
The assertions check several rules on every cycle. The count holds when there is no tick and no write, and it steps by one on a tick that comes without a write. The alarm value changes only under a write. The read data holds between reads. The flag rises only while the count equals the alarm value, and a clear with no tick always drops it. The interrupt stays low while the enable bit is off.

Only the bench scenarios can show the cases that need a value history. These are slice-only loads winning over a tick, the wrap to zero raising the alarm against a zero compare, the suppression of a match caused by a load, set beating clear, and reserved addresses reading zero without side effects.

// File: rtl/rtc_elapsed_pkg.sv
package rtc_elapsed_pkg;

    // Register map, byte offsets on the 16-bit bus; bit 5 selects bank two.
    localparam int CNT_BASE = 'h00;
    localparam int CMP_BASE = 'h08;
    localparam int EN_OFF   = 'h3c;
    localparam int STAT_OFF = 'h3e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CNT,
        SEL_CMP,
        SEL_EN,
        SEL_STAT
    } reg_sel_e;

endpackage

// File: rtl/rtc_reg_decode.sv
module rtc_reg_decode
    import rtc_elapsed_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_WORDS = 3,
    parameter int IDX_W     = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [IDX_W-1:0]  idx
);

    logic [NUM_WORDS-1:0] hit_cnt;
    logic [NUM_WORDS-1:0] hit_cmp;

    genvar g;
    generate
        for (g = 0; g < NUM_WORDS; g++) begin : g_word
            assign hit_cnt[g] = (addr == ADDR_W'(CNT_BASE + 2 * g));
            assign hit_cmp[g] = (addr == ADDR_W'(CMP_BASE + 2 * g));
        end
    endgenerate

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (hit_cnt[i]) begin
                sel = SEL_CNT;
                idx = IDX_W'(i);
            end
            if (hit_cmp[i]) begin
                sel = SEL_CMP;
                idx = IDX_W'(i);
            end
        end
        if (addr == ADDR_W'(EN_OFF))   sel = SEL_EN;
        if (addr == ADDR_W'(STAT_OFF)) sel = SEL_STAT;
    end

endmodule

// File: rtl/rtc_tick_counter.sv
module rtc_tick_counter #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 3,
    parameter int IDX_W     = 2,
    localparam int CNT_W    = WORD_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [WORD_W-1:0] ld_data,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [CNT_W-1:0]  cnt_d,
    output logic              adv
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic [CNT_W-1:0] loaded;

    genvar g;
    generate
        for (g = 0; g < NUM_WORDS; g++) begin : g_slice
            assign loaded[g*WORD_W +: WORD_W] =
                (ld_idx == IDX_W'(g)) ? ld_data : state_q.cnt[g*WORD_W +: WORD_W];
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (ld_en) begin
            state_d.cnt = loaded;
        end else if (tick) begin
            state_d.cnt = state_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cnt_q = state_q.cnt;
    assign cnt_d = state_d.cnt;
    assign adv   = tick && !ld_en;

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 3,
    parameter int IDX_W     = 2,
    localparam int CNT_W    = WORD_W * NUM_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  cnt_next,
    input  logic              adv,
    output logic [CNT_W-1:0]  cmp_q,
    output logic              match
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
    } cmp_state_t;

    cmp_state_t state_d, state_q;
    logic [CNT_W-1:0] written;

    genvar g;
    generate
        for (g = 0; g < NUM_WORDS; g++) begin : g_slice
            assign written[g*WORD_W +: WORD_W] =
                (wr_idx == IDX_W'(g)) ? wr_data : state_q.cmp[g*WORD_W +: WORD_W];
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        if (wr_en) state_d.cmp = written;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign cmp_q = state_q.cmp;
    // A match is an event: only a tick that lands on the alarm value counts.
    assign match = adv && (cnt_next == state_q.cmp);

endmodule

// File: rtl/rtc_elapsed_alarm.sv
module rtc_elapsed_alarm
    import rtc_elapsed_pkg::*;
#(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 3,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              alarm_irq
);

    localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int CNT_W = WORD_W * NUM_WORDS;

    typedef struct packed {
        logic              flag;
        logic              en;
        logic [WORD_W-1:0] rdata;
    } top_state_t;

    top_state_t state_d, state_q;

    reg_sel_e          sel;
    logic [IDX_W-1:0]  idx;
    logic              cnt_ld;
    logic              cmp_wr;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_d;
    logic [CNT_W-1:0]  cmp_q;
    logic              adv;
    logic              match;
    logic              flag_q;
    logic              en_q;

    rtc_reg_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr(bus_addr),
        .sel (sel),
        .idx (idx)
    );

    assign cnt_ld = bus_wr && (sel == SEL_CNT);
    assign cmp_wr = bus_wr && (sel == SEL_CMP);

    rtc_tick_counter #(
        .WORD_W   (WORD_W),
        .NUM_WORDS(NUM_WORDS),
        .IDX_W    (IDX_W)
    ) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .ld_en  (cnt_ld),
        .ld_idx (idx),
        .ld_data(bus_wdata),
        .cnt_q  (cnt_q),
        .cnt_d  (cnt_d),
        .adv    (adv)
    );

    rtc_alarm_cmp #(
        .WORD_W   (WORD_W),
        .NUM_WORDS(NUM_WORDS),
        .IDX_W    (IDX_W)
    ) u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmp_wr),
        .wr_idx  (idx),
        .wr_data (bus_wdata),
        .cnt_next(cnt_d),
        .adv     (adv),
        .cmp_q   (cmp_q),
        .match   (match)
    );

    always_comb begin
        state_d = state_q;

        // Set beats clear when both land in one cycle.
        if (match) begin
            state_d.flag = 1'b1;
        end else if (bus_wr && (sel == SEL_STAT) && bus_wdata[0]) begin
            state_d.flag = 1'b0;
        end

        if (bus_wr && (sel == SEL_EN)) state_d.en = bus_wdata[0];

        if (bus_rd) begin
            case (sel)
                SEL_CNT:  state_d.rdata = cnt_q[int'(idx)*WORD_W +: WORD_W];
                SEL_CMP:  state_d.rdata = cmp_q[int'(idx)*WORD_W +: WORD_W];
                SEL_EN:   state_d.rdata = WORD_W'(state_q.en);
                SEL_STAT: state_d.rdata = WORD_W'(state_q.flag);
                default:  state_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flag_q    = state_q.flag;
    assign en_q      = state_q.en;
    assign bus_rdata = state_q.rdata;
    assign alarm_irq = flag_q & en_q;

endmodule

// File: rtl/rtc_elapsed_alarm_chk.sv
module rtc_elapsed_alarm_chk #(
    parameter int WORD_W    = 16,
    parameter int NUM_WORDS = 3,
    parameter int ADDR_W    = 6,
    localparam int CNT_W    = WORD_W * NUM_WORDS
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [WORD_W-1:0] bus_wdata,
    input logic [WORD_W-1:0] bus_rdata,
    input logic              alarm_irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp,
    input logic              flag,
    input logic              en
);

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !bus_wr) |=> $stable(cnt));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !bus_wr) |=> (cnt == $past(cnt) + CNT_W'(1)));

    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(cmp));

    p_rise_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cnt == cmp));

    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'('h3e) && bus_wdata[0] && !tick_en) |=> !flag);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !alarm_irq);

    p_irq_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_irq) |-> flag);

endmodule

bind rtc_elapsed_alarm rtc_elapsed_alarm_chk #(
    .WORD_W   (WORD_W),
    .NUM_WORDS(NUM_WORDS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .alarm_irq(alarm_irq),
    .cnt      (cnt_q),
    .cmp      (cmp_q),
    .flag     (flag_q),
    .en       (en_q)
);

// File: tb/rtc_elapsed_alarm_test.sv
`timescale 1ns/1ps
module rtc_elapsed_alarm_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_rdata;
    logic        alarm_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [47:0] m_cnt = '0;
    logic [47:0] m_cmp = '0;
    logic        m_flag = 1'b0;
    logic        m_en = 1'b0;
    logic [15:0] m_rd = '0;

    always #2.5 clk = ~clk;

    rtc_elapsed_alarm uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
    );

    function automatic logic [15:0] model_read(logic [5:0] a);
        case (a)
            6'h00: return m_cnt[15:0];
            6'h02: return m_cnt[31:16];
            6'h04: return m_cnt[47:32];
            6'h08: return m_cmp[15:0];
            6'h0a: return m_cmp[31:16];
            6'h0c: return m_cmp[47:32];
            6'h3c: return {15'd0, m_en};
            6'h3e: return {15'd0, m_flag};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(string req, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One bus/tick cycle; model advances on the same edge as the design.
    task automatic step(bit t, bit w, bit r, logic [5:0] a, logic [15:0] d);
        logic [47:0] n_cnt;
        logic [47:0] n_cmp;
        logic        ld;
        logic        match;
        @(negedge clk);
        tick_en = t; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
        n_cnt = m_cnt;
        n_cmp = m_cmp;
        ld = w && (a == 6'h00 || a == 6'h02 || a == 6'h04);
        if (ld) n_cnt[a[2:1]*16 +: 16] = d;
        else if (t) n_cnt = m_cnt + 48'd1;
        if (w && (a == 6'h08 || a == 6'h0a || a == 6'h0c)) n_cmp[(a[2:1]-2'd0)*16 +: 16] = d;
        match = t && !ld && (n_cnt == m_cmp);
        if (r) m_rd = model_read(a);
        @(posedge clk);
        #1;
        if (match) m_flag = 1'b1;
        else if (w && a == 6'h3e && d[0]) m_flag = 1'b0;
        if (w && a == 6'h3c) m_en = d[0];
        m_cnt = n_cnt;
        m_cmp = n_cmp;
        tick_en = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic rd_chk(logic [5:0] a, string req);
        step(1'b0, 1'b0, 1'b1, a, 16'h0);
        chk(req, {32'd0, bus_rdata}, {32'd0, m_rd});
    endtask

    task automatic cnt_chk(string req);
        rd_chk(6'h00, req);
        rd_chk(6'h02, req);
        rd_chk(6'h04, req);
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed_2024);
        #12;
        chk("R1 rdata", {32'd0, bus_rdata}, 48'd0);
        chk("R1 irq", {47'd0, alarm_irq}, 48'd0);
        rst_n = 1'b1;
        // R1: everything reads zero after reset
        cnt_chk("R1 count");
        rd_chk(6'h08, "R1 cmp"); rd_chk(6'h0a, "R1 cmp"); rd_chk(6'h0c, "R1 cmp");
        rd_chk(6'h3e, "R1 status"); rd_chk(6'h3c, "R1 enable");

        // R2: one step per tick, hold when idle
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 6'h00, 16'h0);
        rd_chk(6'h00, "R2 ticks");
        chk("R2 value", m_cnt, 48'd5);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 6'h00, 16'h0);
        cnt_chk("R2 hold");

        // R3: read data held between reads, even across ticks
        rd_chk(6'h00, "R3 low");
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 1'b0, 1'b0, 6'h00, 16'h0);
            chk("R3 held", {32'd0, bus_rdata}, 48'd5);
        end

        // R4: slice load beats tick, other slices unchanged
        step(1'b1, 1'b1, 1'b0, 6'h02, 16'h1234);
        cnt_chk("R4 slice load");
        chk("R4 model", m_cnt, 48'h0000_1234_0008);

        // R2 wrap: all ones plus one tick; compare is zero so R6 fires too
        step(1'b0, 1'b1, 1'b0, 6'h00, 16'hffff);
        step(1'b0, 1'b1, 1'b0, 6'h02, 16'hffff);
        step(1'b0, 1'b1, 1'b0, 6'h04, 16'hffff);
        step(1'b1, 1'b0, 1'b0, 6'h00, 16'h0);
        chk("R2 wrap", m_cnt, 48'd0);
        cnt_chk("R2 wrap read");
        rd_chk(6'h3e, "R6 wrap match");
        chk("R8 gated off", {47'd0, alarm_irq}, 48'd0);

        // R7: write 0 keeps, write 1 clears
        step(1'b0, 1'b1, 1'b0, 6'h3e, 16'hfffe);
        rd_chk(6'h3e, "R7 write0 keeps");
        step(1'b0, 1'b1, 1'b0, 6'h3e, 16'h0001);
        rd_chk(6'h3e, "R7 write1 clears");

        // R5: compare write and readback, count untouched
        step(1'b0, 1'b1, 1'b0, 6'h08, 16'h0010);
        step(1'b0, 1'b1, 1'b0, 6'h0a, 16'h0000);
        rd_chk(6'h08, "R5 cmp low");
        rd_chk(6'h0a, "R5 cmp mid");
        cnt_chk("R5 count untouched");

        // R6: load onto alarm value does not set; idle equality does not set
        step(1'b0, 1'b1, 1'b0, 6'h00, 16'h0010);
        step(1'b0, 1'b0, 1'b0, 6'h00, 16'h0);
        rd_chk(6'h3e, "R6 load no set");
        step(1'b1, 1'b0, 1'b0, 6'h00, 16'h0);
        rd_chk(6'h3e, "R6 pass no set");
        step(1'b0, 1'b1, 1'b0, 6'h00, 16'h000e);
        step(1'b1, 1'b0, 1'b0, 6'h00, 16'h0);
        rd_chk(6'h3e, "R6 one short");
        step(1'b1, 1'b0, 1'b0, 6'h00, 16'h0);
        rd_chk(6'h3e, "R6 tick match");
        chk("R6 model", {47'd0, m_flag}, 48'd1);

        // R8: enable gates irq
        step(1'b0, 1'b1, 1'b0, 6'h3c, 16'h0001);
        chk("R8 irq on", {47'd0, alarm_irq}, 48'd1);
        rd_chk(6'h3c, "R8 enable read");
        step(1'b0, 1'b1, 1'b0, 6'h3c, 16'h0000);
        chk("R8 irq off", {47'd0, alarm_irq}, 48'd0);
        step(1'b0, 1'b1, 1'b0, 6'h3c, 16'h0001);

        // R7: set wins over clear in the same cycle
        step(1'b0, 1'b1, 1'b0, 6'h3e, 16'h0001);
        chk("R7 cleared", {47'd0, alarm_irq}, 48'd0);
        step(1'b0, 1'b1, 1'b0, 6'h00, 16'h000f);
        step(1'b1, 1'b1, 1'b0, 6'h3e, 16'h0001);
        chk("R7 set beats clear", {47'd0, alarm_irq}, 48'd1);
        rd_chk(6'h3e, "R7 set beats clear read");

        // R9: reserved and unmapped addresses read zero, writes inert
        step(1'b0, 1'b1, 1'b0, 6'h06, 16'hffff);
        step(1'b0, 1'b1, 1'b0, 6'h0e, 16'hffff);
        step(1'b0, 1'b1, 1'b0, 6'h1e, 16'hffff);
        step(1'b0, 1'b1, 1'b0, 6'h21, 16'hffff);
        step(1'b0, 1'b1, 1'b0, 6'h3f, 16'hffff);
        rd_chk(6'h06, "R9 reserved 06");
        rd_chk(6'h0e, "R9 reserved 0e");
        rd_chk(6'h01, "R9 odd addr");
        rd_chk(6'h1e, "R9 bank one 1e");
        cnt_chk("R9 count untouched");
        rd_chk(6'h0c, "R9 cmp untouched");
        rd_chk(6'h3e, "R9 flag untouched");
        rd_chk(6'h3c, "R9 enable untouched");

        // Random mix, all requirements against the model
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] a;
            int unsigned op;
            bit t;
            t = ($urandom_range(0, 3) != 0);
            case ($urandom_range(0, 11))
                0: a = 6'h00; 1: a = 6'h02; 2: a = 6'h04; 3: a = 6'h06;
                4: a = 6'h08; 5: a = 6'h0a; 6: a = 6'h0c; 7: a = 6'h0e;
                8: a = 6'h3c; 9: a = 6'h3e; 10: a = 6'h1e; default: a = 6'h21;
            endcase
            op = $urandom_range(0, 9);
            if (op < 4) begin
                step(t, 1'b0, 1'b1, a, 16'h0);
                chk("R3 random read", {32'd0, bus_rdata}, {32'd0, m_rd});
            end else if (op < 6) begin
                step(t, 1'b1, 1'b0, a, 16'($urandom));
            end else if (op == 6) begin
                // park the alarm just ahead of the count to provoke R6
                step(1'b0, 1'b1, 1'b0, 6'h08, m_cnt[15:0] + 16'd3);
            end else begin
                step(t, 1'b0, 1'b0, 6'h00, 16'h0);
            end
            chk("R8 random irq", {47'd0, alarm_irq}, {47'd0, m_flag & m_en});
        end
        cnt_chk("R2 random final");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule